// File: doc/BRIEF.md
# Vectored External Interrupt Controller

The block gathers eight active-low external request lines into one interrupt output and a vector code. Each line is configured on its own to raise a request either on a falling edge or for as long as it is held low. Edge requests are kept in a pending latch until software clears them. Level requests follow the input and are never latched. A per-line enable gates requests into the combined interrupt output and into a priority encoder. The encoder yields an 8-bit code whose two low bits are always zero, so the code can index a branch table directly.

A separate per-line wake enable drives a wake output, which brings the system out of low-power mode. The wake output is taken from detected requests before the interrupt enable is applied.

Software reaches four 32-bit registers through a simple read/write port with byte, half-word and word access. Byte lanes are numbered big-endian: byte offset 0 is bits 31:24. Read data is returned right-justified and zero-extended. Every request input passes through a two-flop synchronizer before it is used.

Top module: `ext_irq_vec`

## Requirements
- R1: After reset, the config, enable and status registers read 0, the vector word reads 0x2000_0000, and irq_o and wake_o are 0.
- R2: The config register (word address 0) is read/write. For line n, bit 31-2n selects edge mode (1) or level mode (0), and bit 30-2n is the wake enable.
- R3: In level mode, a line held low is a detected request, and the request ends once the line returns high. It is visible at the outputs two clocks after the input changes.
- R4: In edge mode, a high-to-low transition of the synchronized line sets that line's pending bit. The bit stays set after the line goes high again. A line that stays low creates no further request.
- R5: Writing 1 to bit n of the status register (word address 2) clears line n's pending bit. Writing 0 leaves it unchanged. Reading the status register returns the detected requests (bits 7:0) before the enable is applied.
- R6: The enable register (word address 1, bits 7:0, 1 = enabled) gates requests. irq_o is the OR of all detected requests whose line is enabled.
- R7: The vector register (word address 3, bits 31:24) holds 4 times the lowest-numbered enabled detected line. Line 0 has the highest priority.
- R8: When no enabled request is present, the vector code is the idle value 32.
- R9: A byte read at byte address 0xC returns the code. A half-word read there returns the code times 256. A word read returns the code shifted left by 24.
- R10: wake_o is 1 while any detected request has its wake enable set, whatever the enable register holds.
- R11: Byte and half-word writes change only the addressed lanes of a register.
- R12: Writes to the vector register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 8 | External request lines, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 4 | Byte address (bits 3:2 select the word, bits 1:0 the lane) |
| size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| wdata_i | input | 32 | Write data, right-justified |
| rdata_o | output | 32 | Read data, right-justified and zero-extended |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
A line held low in level mode is compared with a short low pulse in edge mode. After release, the first must drop and the second must persist. A line that stays low across a pending clear shows that an edge fires once and not for every low sample. Two lines low together, with the enable of the winner then removed, tell the priority order apart from simple masking. A disabled line with its wake enable set tells the wake path apart from the interrupt path. Reads of the same code as a byte, a half-word and a word, together with partial writes to the config register, expose errors in lane steering.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  localparam int unsigned REG_W = 32;

  // big-endian lane placement: offset 0 sits at bits 31:24
  function automatic logic [4:0] lane_shift(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      ACC_BYTE: return {2'd3 - off, 3'b000};
      ACC_HALF: return off[1] ? 5'd0 : 5'd16;
      default:  return 5'd0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      ACC_BYTE: return 32'h0000_00ff;
      ACC_HALF: return 32'h0000_ffff;
      default:  return 32'hffff_ffff;
    endcase
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_ni,
  output logic [N-1:0] low_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= irq_ni;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign low_o  = ~sync_q;
  assign fall_o = prev_q & ~sync_q;

endmodule

// File: rtl/ext_irq_pend.sv
module ext_irq_pend #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] edge_sel_i,
  input  logic [N-1:0] low_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] det_o
);

  logic [N-1:0] pend_q;
  logic [N-1:0] set_w;

  assign set_w = edge_sel_i & fall_i;

  // a new edge wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_w;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    assign det_o[g] = edge_sel_i[g] ? pend_q[g] : low_i[g];
  end

  a_r4_edge_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_w != '0) |=> ((pend_q & $past(set_w)) == $past(set_w)));

  a_r5_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_w) != '0) |=> ((pend_q & $past(clr_i & ~set_w)) == '0));

endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o,
  output logic          hit_o
);

  localparam logic [CW-1:0] IDLE = CW'(4 * N);

  always_comb begin
    code_o = IDLE;
    hit_o  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o = CW'(4 * i);
        hit_o  = 1'b1;
      end
    end
  end

  logic [CW-3:0] idx_w;
  assign idx_w = code_o[CW-1:2];

  a_r7_hit_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (req_i[idx_w] && code_o[1:0] == 2'b00));

  a_r7_no_higher: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((req_i & ~({N{1'b1}} << idx_w)) == '0));

  a_r8_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (code_o == IDLE && req_i == '0));

endmodule

// File: rtl/ext_irq_vec.sv
module ext_irq_vec
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned CODE_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_LINES-1:0]   irq_ni,
  input  logic                 we_i,
  input  logic [3:0]           addr_i,
  input  logic [1:0]           size_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 irq_o,
  output logic                 wake_o
);

  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_ENA = 2'd1;
  localparam logic [1:0] A_STS = 2'd2;
  localparam logic [1:0] A_VEC = 2'd3;

  logic [REG_W-1:0]   cfg_q;
  logic [N_LINES-1:0] ena_q;
  logic [N_LINES-1:0] edge_sel, wake_en, low_w, fall_w, det_w, clr_w;
  logic [CODE_W-1:0]  code_w;
  logic               hit_w;

  // write lane steering
  logic [4:0]       shamt;
  logic [REG_W-1:0] wmask, wval, rword;

  assign shamt = lane_shift(size_i, addr_i[1:0]);
  assign wmask = size_mask(size_i) << shamt;
  assign wval  = (wdata_i & size_mask(size_i)) << shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ena_q <= '0;
    end else if (we_i) begin
      if (addr_i[3:2] == A_CFG) cfg_q <= (cfg_q & ~wmask) | (wval & wmask);
      if (addr_i[3:2] == A_ENA)
        ena_q <= (ena_q & ~wmask[N_LINES-1:0]) | (wval[N_LINES-1:0] & wmask[N_LINES-1:0]);
    end
  end

  assign clr_w = (we_i && addr_i[3:2] == A_STS) ? (wval[N_LINES-1:0] & wmask[N_LINES-1:0])
                                                 : '0;

  for (genvar g = 0; g < N_LINES; g++) begin : g_cfg
    assign edge_sel[g] = cfg_q[REG_W-1-2*g];
    assign wake_en[g]  = cfg_q[REG_W-2-2*g];
  end

  ext_irq_sync #(.N(N_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_ni (irq_ni),
    .low_o  (low_w),
    .fall_o (fall_w)
  );

  ext_irq_pend #(.N(N_LINES)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_sel_i (edge_sel),
    .low_i      (low_w),
    .fall_i     (fall_w),
    .clr_i      (clr_w),
    .det_o      (det_w)
  );

  ext_irq_prio #(.N(N_LINES), .CW(CODE_W)) u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (det_w & ena_q),
    .code_o (code_w),
    .hit_o  (hit_w)
  );

  assign irq_o  = |(det_w & ena_q);
  assign wake_o = |(det_w & wake_en);

  always_comb begin
    case (addr_i[3:2])
      A_CFG:   rword = cfg_q;
      A_ENA:   rword = REG_W'(ena_q);
      A_STS:   rword = REG_W'(det_w);
      default: rword = {code_w, {(REG_W-CODE_W){1'b0}}};
    endcase
    rdata_o = (rword >> shamt) & size_mask(size_i);
  end

  a_r6_irq_matches_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == hit_w);

  a_r12_vec_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[3:2] == A_VEC) |=> ($stable(cfg_q) && $stable(ena_q)));

endmodule

// File: tb/ext_irq_vec_test.sv
module ext_irq_vec_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_ni = 8'hff;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [1:0]  size_i = 2'd2;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_irq_vec uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_ni(irq_ni), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  localparam logic [1:0] SB = 2'd0, SH = 2'd1, SW = 2'd2;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; size_i = sz; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    addr_i = a; size_i = sz;
    #2 d = rdata_o;
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk);
    irq_ni[n] = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #2;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, SW, d); chk("R1 cfg", d, 0);
    rd(4'h4, SW, d); chk("R1 ena", d, 0);
    rd(4'h8, SW, d); chk("R1 sts", d, 0);
    rd(4'hC, SW, d); chk("R1 vec", d, 32'h2000_0000);
    chk("R1 irq", irq_o, 0);
    chk("R1 wake", wake_o, 0);
  endtask

  task automatic t_cfg_rw();
    logic [31:0] d;
    wr(4'h0, SW, 32'h8000_0001);
    rd(4'h0, SW, d); chk("R2 cfg readback", d, 32'h8000_0001);
    wr(4'h0, SW, 32'h0);
    wr(4'h1, SB, 32'hAB);
    rd(4'h0, SW, d); chk("R11 byte write lane", d, 32'h00AB_0000);
    wr(4'h2, SH, 32'h1234);
    rd(4'h0, SW, d); chk("R11 half write lane", d, 32'h00AB_1234);
    rd(4'h2, SB, d); chk("R11 byte read lane", d, 32'h12);
    wr(4'h0, SW, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(4'h4, SW, 32'hff);
    line(5, 1'b0); settle();
    chk("R3 level irq", irq_o, 1);
    rd(4'hC, SB, d); chk("R7 level code", d, 20);
    line(5, 1'b1); settle();
    chk("R3 level released", irq_o, 0);
    rd(4'hC, SB, d); chk("R8 idle after level", d, 32);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(4'h0, SW, 32'h0800_0000);  // line 2 edge mode (bit 27)
    line(2, 1'b0); settle();
    line(2, 1'b1); settle();
    chk("R4 edge held", irq_o, 1);
    rd(4'h8, SW, d); chk("R5 status pending", d, 32'h4);
    rd(4'hC, SB, d); chk("R7 edge code", d, 8);
    wr(4'h8, SW, 32'h0);
    chk("R5 zero write keeps", irq_o, 1);
    wr(4'h8, SW, 32'h4);
    #2 chk("R5 cleared", irq_o, 0);
    line(2, 1'b0); settle();
    chk("R4 second edge", irq_o, 1);
    wr(4'h8, SB | 2'd0, 32'h0);
    wr(4'hB, SB, 32'h4);
    settle();
    chk("R4 held low no refire", irq_o, 0);
    line(2, 1'b1); settle();
    wr(4'h0, SW, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(4'h4, SW, 32'h0);
    line(1, 1'b0); settle();
    chk("R6 masked irq", irq_o, 0);
    rd(4'hC, SB, d); chk("R8 masked idle", d, 32);
    rd(4'h8, SW, d); chk("R5 status premask", d, 32'h2);
    wr(4'h7, SB, 32'h02);
    #2 chk("R6 enabled irq", irq_o, 1);
    line(1, 1'b1); settle();
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(4'h4, SW, 32'hff);
    line(6, 1'b0); line(3, 1'b0); settle();
    rd(4'hC, SB, d); chk("R7 priority low line", d, 12);
    rd(4'hC, SH, d); chk("R9 half read", d, 12 * 256);
    rd(4'hC, SW, d); chk("R9 word read", d, 32'h0C00_0000);
    rd(4'hD, SB, d); chk("R9 other lane zero", d, 0);
    wr(4'h4, SW, 32'hf7);
    rd(4'hC, SB, d); chk("R7 next priority", d, 24);
    wr(4'hC, SW, 32'hffff_ffff);
    rd(4'hC, SB, d); chk("R12 vec ignores write", d, 24);
    rd(4'h4, SW, d); chk("R12 ena untouched", d, 32'hf7);
    line(6, 1'b1); line(3, 1'b1); settle();
  endtask

  task automatic t_wake();
    logic [31:0] d;
    wr(4'h4, SW, 32'h0);
    wr(4'h0, SW, 32'h0040_0000);  // line 4 wake (bit 22)
    line(4, 1'b0); settle();
    chk("R10 wake while masked", wake_o, 1);
    chk("R10 irq stays low", irq_o, 0);
    line(4, 1'b1); line(1, 1'b0); settle();
    chk("R10 no wake without enable", wake_o, 0);
    line(1, 1'b1); settle();
    rd(4'h0, SW, d); chk("R2 wake bit readback", d, 32'h0040_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_cfg_rw();
    t_level();
    t_edge();
    t_mask();
    t_prio();
    t_wake();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule